// File: doc/BRIEF.md
# Source-Routed Port Switch with Leading Element Strip

This block forwards packets without any routing table. Each packet carries, in its first beat, a path address: a list of per-hop output port numbers, packed most-significant first, with a length count in front of it. The switch reads only the element at the head of that list. It sends the whole packet to the output port that the element names, and it rewrites the first beat so that the next hop finds its own element at the head.

The width of the element is set by the port count of this node. It is the smallest number of bits that can hold the highest port number, so 1 port needs 1 bit, 3 ports need 2 bits and 4 ports need 3 bits. Ports are numbered from 1, so an element value of 0 is never a valid port. A packet whose element is out of range, or whose address has too few bits left, goes to a separate discard stream together with a reason code. Each egress has a single output register. When the chosen egress cannot take a beat, the input is held, and a packet always leaves by exactly one egress.

Top module: `vas_switch`

## Requirements
- R1: The element width EW is ceil(log2(NUM_PORTS+1)) bits. With the defaults this is 3 bits. The element is taken from the top EW bits of the address field, which occupies bits [ADDR_W-1:0] of the first beat, where ADDR_W = DATA_W-LEN_W.
- R2: If the first beat of a packet holds element p with 1 <= p <= NUM_PORTS and a valid length, the beat appears on egress p-1 (bit p-1 of `out_valid`, data slice [(p-1)*DATA_W +: DATA_W]) on the clock edge that accepts it. No other egress and no discard output asserts valid for that beat.
- R3: On a forwarded first beat, the length field in bits [DATA_W-1 -: LEN_W] is reduced by EW. The address field is shifted left by EW, with zeros filling in from the bottom.
- R4: Every beat after the first, up to and including the beat marked with `in_eop`, passes unchanged to the same egress as the first beat. The sop and eop markers pass through unchanged.
- R5: If the element value is 0 or greater than NUM_PORTS, the whole packet goes to the discard output unchanged, with `drop_code` = 2'b01 on every beat.
- R6: If the length field is smaller than EW or greater than ADDR_W, the packet is discarded with `drop_code` = 2'b10. This check takes priority over the element check of R5.
- R7: While the selected egress holds a beat that it is not releasing, `in_ready` is low and no beat is taken. Once that egress is released, the held input beat is accepted.
- R8: After reset, all egress valids and the discard valid are low. With all output registers empty, `in_ready` is high.
- R9: An egress or discard output whose valid is high and whose ready is low keeps its valid and data unchanged in the next cycle.
- R10: Only the first beat after reset or after an eop beat is decoded as a header. A later beat whose content would decode to a different port, or to an invalid one, still follows the packet unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Input beat taken on this edge when valid |
| in_data | input | DATA_W | Input beat; first beat is {length, address} |
| in_sop | input | 1 | Start of packet marker (passed through) |
| in_eop | input | 1 | Last beat of packet |
| out_valid | output | NUM_PORTS | Per-egress beat present |
| out_ready | input | NUM_PORTS | Per-egress consumer ready |
| out_data | output | NUM_PORTS*DATA_W | Per-egress beat data, egress i at slice i |
| out_sop | output | NUM_PORTS | Per-egress start marker |
| out_eop | output | NUM_PORTS | Per-egress end marker |
| drop_valid | output | 1 | Discard stream beat present |
| drop_ready | input | 1 | Discard consumer ready |
| drop_data | output | DATA_W | Discarded beat, unchanged |
| drop_sop | output | 1 | Discard start marker |
| drop_eop | output | 1 | Discard end marker |
| drop_code | output | 2 | Reason: 01 bad element, 10 bad length |

## Verification
Several properties are checked on every cycle. At most one destination register loads per edge, and an accepted beat always shows up on some output on the next edge. No beat is taken while the input is stalled, every discard beat carries a non-zero reason code, and a held output keeps its valid and data. Other behaviour is shown only by the bench's scenarios. These cover the exact header rewrite, the decoding of each element value, the priority of the length check over the element check, whole packets following their first beat, and the release of a stall once an egress drains.

// File: rtl/vas_pkg.sv
`timescale 1ns/1ps
package vas_pkg;

  // Reason attached to discarded beats; encodings are visible on drop_code.
  typedef enum logic [1:0] {
    DROP_NONE    = 2'b00,
    DROP_BADPORT = 2'b01,
    DROP_BADLEN  = 2'b10
  } drop_code_e;

  // Bits needed to hold port numbers 1..n (also holds an index 0..n).
  function automatic int elem_width(input int n);
    return $clog2(n + 1);
  endfunction

endpackage

// File: rtl/vas_hdr_decode.sv
`timescale 1ns/1ps
// Combinational decode and rewrite of a first beat.
module vas_hdr_decode #(
  parameter int NUM_PORTS = 4,
  parameter int DATA_W    = 16,
  parameter int LEN_W     = 4,
  localparam int ADDR_W   = DATA_W - LEN_W,
  localparam int EW       = vas_pkg::elem_width(NUM_PORTS)
) (
  input  logic [DATA_W-1:0]      hdr_in,
  output logic [DATA_W-1:0]      hdr_out,
  output logic [EW-1:0]          port_idx,
  output logic                   drop,
  output vas_pkg::drop_code_e    code
);

  localparam logic [LEN_W-1:0] EW_L   = LEN_W'(EW);
  localparam logic [LEN_W-1:0] ADDR_L = LEN_W'(ADDR_W);
  localparam logic [EW-1:0]    MAXP   = EW'(NUM_PORTS);

  logic [LEN_W-1:0]  len_f;
  logic [ADDR_W-1:0] addr_f;
  logic [ADDR_W-1:0] addr_sh;
  logic [LEN_W-1:0]  len_new;
  logic [EW-1:0]     elem;
  logic              len_bad;
  logic              elem_bad;

  always_comb begin
    len_f    = hdr_in[DATA_W-1 -: LEN_W];
    addr_f   = hdr_in[ADDR_W-1:0];
    elem     = addr_f[ADDR_W-1 -: EW];
    len_bad  = (len_f < EW_L) || (len_f > ADDR_L);
    elem_bad = (elem == '0) || (elem > MAXP);
    addr_sh  = addr_f << EW;
    len_new  = len_f - EW_L;
    hdr_out  = {len_new, addr_sh};
    port_idx = elem - EW'(1);
    if (len_bad) begin
      drop = 1'b1;
      code = vas_pkg::DROP_BADLEN;
    end else if (elem_bad) begin
      drop = 1'b1;
      code = vas_pkg::DROP_BADPORT;
    end else begin
      drop = 1'b0;
      code = vas_pkg::DROP_NONE;
    end
  end

endmodule

// File: rtl/vas_route_ctl.sv
`timescale 1ns/1ps
// Packet framing and destination hold. Destination index NUM_PORTS is the discard stream.
module vas_route_ctl #(
  parameter int NUM_PORTS = 4,
  localparam int EW       = vas_pkg::elem_width(NUM_PORTS),
  localparam int ND       = NUM_PORTS + 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic                in_eop,
  input  logic                hdr_drop,
  input  logic [EW-1:0]       hdr_port,
  input  vas_pkg::drop_code_e hdr_code,
  input  logic [ND-1:0]       dest_ready,
  output logic                in_ready,
  output logic [ND-1:0]       load_vec,
  output logic                is_hdr,
  output vas_pkg::drop_code_e beat_code
);

  localparam logic [EW-1:0] DROP_IDX = EW'(NUM_PORTS);

  logic                in_pkt;
  logic [EW-1:0]       cur_dest;
  vas_pkg::drop_code_e cur_code;
  logic [EW-1:0]       dest;
  logic                fire;

  always_comb begin
    is_hdr    = !in_pkt;
    dest      = is_hdr ? (hdr_drop ? DROP_IDX : hdr_port) : cur_dest;
    beat_code = is_hdr ? hdr_code : cur_code;
    in_ready  = dest_ready[dest];
    fire      = in_valid && in_ready;
    load_vec  = '0;
    for (int i = 0; i < ND; i++) begin
      if (fire && (dest == EW'(i))) load_vec[i] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      in_pkt   <= 1'b0;
      cur_dest <= '0;
      cur_code <= vas_pkg::DROP_NONE;
    end else if (fire) begin
      in_pkt <= !in_eop;
      if (is_hdr) begin
        cur_dest <= dest;
        cur_code <= hdr_code;
      end
    end
  end

endmodule

// File: rtl/vas_out_stage.sv
`timescale 1ns/1ps
// One-entry registered output; data registers carry no reset.
module vas_out_stage #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d,
  input  logic         ready,
  output logic         can_take,
  output logic         q_valid,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)        q_valid <= 1'b0;
    else if (load)  q_valid <= 1'b1;
    else if (ready) q_valid <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (load) q <= d;
  end

  assign can_take = !q_valid || ready;

endmodule

// File: rtl/vas_switch.sv
`timescale 1ns/1ps
module vas_switch #(
  parameter int NUM_PORTS = 4,
  parameter int DATA_W    = 16,
  parameter int LEN_W     = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          in_valid,
  output logic                          in_ready,
  input  logic [DATA_W-1:0]             in_data,
  input  logic                          in_sop,
  input  logic                          in_eop,
  output logic [NUM_PORTS-1:0]          out_valid,
  input  logic [NUM_PORTS-1:0]          out_ready,
  output logic [NUM_PORTS*DATA_W-1:0]   out_data,
  output logic [NUM_PORTS-1:0]          out_sop,
  output logic [NUM_PORTS-1:0]          out_eop,
  output logic                          drop_valid,
  input  logic                          drop_ready,
  output logic [DATA_W-1:0]             drop_data,
  output logic                          drop_sop,
  output logic                          drop_eop,
  output logic [1:0]                    drop_code
);

  localparam int EW = vas_pkg::elem_width(NUM_PORTS);
  localparam int ND = NUM_PORTS + 1;
  localparam int PW = DATA_W + 2;
  localparam int DW = DATA_W + 4;

  logic [DATA_W-1:0]   hdr_new;
  logic [EW-1:0]       hdr_port;
  logic                hdr_drop;
  vas_pkg::drop_code_e hdr_code;
  vas_pkg::drop_code_e beat_code;
  logic                is_hdr;
  logic [ND-1:0]       dest_ready;
  logic [ND-1:0]       load_vec;
  logic [DATA_W-1:0]   fwd_data;

  vas_hdr_decode #(
    .NUM_PORTS(NUM_PORTS), .DATA_W(DATA_W), .LEN_W(LEN_W)
  ) u_dec (
    .hdr_in  (in_data),
    .hdr_out (hdr_new),
    .port_idx(hdr_port),
    .drop    (hdr_drop),
    .code    (hdr_code)
  );

  vas_route_ctl #(.NUM_PORTS(NUM_PORTS)) u_ctl (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_eop    (in_eop),
    .hdr_drop  (hdr_drop),
    .hdr_port  (hdr_port),
    .hdr_code  (hdr_code),
    .dest_ready(dest_ready),
    .in_ready  (in_ready),
    .load_vec  (load_vec),
    .is_hdr    (is_hdr),
    .beat_code (beat_code)
  );

  assign fwd_data = is_hdr ? hdr_new : in_data;

  for (genvar i = 0; i < ND; i++) begin : g_dst
    if (i < NUM_PORTS) begin : g_port
      logic [PW-1:0] q;
      vas_out_stage #(.W(PW)) u_stage (
        .clk     (clk),
        .rst     (rst),
        .load    (load_vec[i]),
        .d       ({fwd_data, in_sop, in_eop}),
        .ready   (out_ready[i]),
        .can_take(dest_ready[i]),
        .q_valid (out_valid[i]),
        .q       (q)
      );
      assign out_data[i*DATA_W +: DATA_W] = q[PW-1 -: DATA_W];
      assign out_sop[i] = q[1];
      assign out_eop[i] = q[0];
    end else begin : g_drop
      logic [DW-1:0] q;
      vas_out_stage #(.W(DW)) u_stage (
        .clk     (clk),
        .rst     (rst),
        .load    (load_vec[i]),
        .d       ({in_data, in_sop, in_eop, beat_code}),
        .ready   (drop_ready),
        .can_take(dest_ready[i]),
        .q_valid (drop_valid),
        .q       (q)
      );
      assign drop_data = q[DW-1 -: DATA_W];
      assign drop_sop  = q[3];
      assign drop_eop  = q[2];
      assign drop_code = q[1:0];
    end
  end

endmodule

// File: rtl/vas_switch_chk.sv
`timescale 1ns/1ps
module vas_switch_chk #(
  parameter int NUM_PORTS = 4,
  parameter int DATA_W    = 16
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        in_valid,
  input logic                        in_ready,
  input logic [NUM_PORTS-1:0]        out_valid,
  input logic [NUM_PORTS-1:0]        out_ready,
  input logic [NUM_PORTS*DATA_W-1:0] out_data,
  input logic                        drop_valid,
  input logic                        drop_ready,
  input logic [DATA_W-1:0]           drop_data,
  input logic [1:0]                  drop_code,
  input logic [NUM_PORTS:0]          load_vec
);

  p_reset_clear_r8: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (out_valid == '0 && !drop_valid));

  p_one_dest_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(load_vec));

  p_accept_lands_r2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> (out_valid != '0 || drop_valid));

  p_stall_no_load_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_ready) |-> (load_vec == '0));

  p_drop_reason_r5: assert property (@(posedge clk) disable iff (rst)
    drop_valid |-> (drop_code != 2'b00));

  p_drop_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (drop_valid && !drop_ready) |=> (drop_valid && $stable(drop_data)));

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_hold
    p_port_hold_r9: assert property (@(posedge clk) disable iff (rst)
      (out_valid[i] && !out_ready[i]) |=>
        (out_valid[i] && $stable(out_data[i*DATA_W +: DATA_W])));
  end

endmodule

bind vas_switch vas_switch_chk #(.NUM_PORTS(NUM_PORTS), .DATA_W(DATA_W)) u_vas_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .drop_valid(drop_valid),
  .drop_ready(drop_ready),
  .drop_data (drop_data),
  .drop_code (drop_code),
  .load_vec  (load_vec)
);

// File: tb/vas_switch_bench.sv
`timescale 1ns/1ps
module vas_switch_bench;

  localparam int NP = 4;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [DW-1:0] in_data = '0;
  logic          in_sop = 1'b0;
  logic          in_eop = 1'b0;
  logic [NP-1:0] out_valid;
  logic [NP-1:0] out_ready = '1;
  logic [NP*DW-1:0] out_data;
  logic [NP-1:0] out_sop;
  logic [NP-1:0] out_eop;
  logic          drop_valid;
  logic          drop_ready = 1'b1;
  logic [DW-1:0] drop_data;
  logic          drop_sop;
  logic          drop_eop;
  logic [1:0]    drop_code;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  vas_switch #(.NUM_PORTS(NP), .DATA_W(DW), .LEN_W(4)) u_vas_switch (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_sop(in_sop), .in_eop(in_eop),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sop(out_sop), .out_eop(out_eop),
    .drop_valid(drop_valid), .drop_ready(drop_ready), .drop_data(drop_data),
    .drop_sop(drop_sop), .drop_eop(drop_eop), .drop_code(drop_code)
  );

  // dest: 0..3 egress index, 4 = discard
  typedef struct packed {
    logic [15:0] hdr;
    logic [15:0] body;
    logic [2:0]  dest;
    logic [15:0] ehdr;
    logic [1:0]  code;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{16'h68C0, 16'hB000, 3'd3, 16'h3600, 2'd0},  // element 4
    '{16'h3200, 16'hB001, 3'd0, 16'h0000, 2'd0},  // element 1, length equals EW
    '{16'hC555, 16'hB002, 3'd1, 16'h9AA8, 2'd0},  // element 2, full address
    '{16'h5780, 16'hB003, 3'd2, 16'h2C00, 2'd0},  // element 3
    '{16'h60C0, 16'hB004, 3'd4, 16'h60C0, 2'd1},  // element 0
    '{16'h3A00, 16'hB005, 3'd4, 16'h3A00, 2'd1},  // element 5
    '{16'h4E00, 16'hB006, 3'd4, 16'h4E00, 2'd1},  // element 7
    '{16'h2400, 16'hB007, 3'd4, 16'h2400, 2'd2},  // length below EW
    '{16'hD200, 16'hB008, 3'd4, 16'hD200, 2'd2},  // length above address field
    '{16'h0000, 16'hB009, 3'd4, 16'h0000, 2'd2}   // both bad: length wins
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // Drive one beat, wait for acceptance, return 2 ns after the accepting edge.
  task automatic send(input logic [DW-1:0] d, input logic s, input logic e);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_sop = s; in_eop = e;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #2;
    in_valid = 1'b0;
  endtask

  // Check the beat just registered against its expected destination.
  task automatic expect_beat(input string req, input logic [2:0] dest,
                             input logic [DW-1:0] d, input logic s, input logic e,
                             input logic [1:0] code);
    logic [NP-1:0] ev;
    ev = (dest < 3'd4) ? NP'(1) << dest : '0;
    check(req, "out_valid", 32'(out_valid), 32'(ev));
    check(req, "drop_valid", 32'(drop_valid), 32'(dest == 3'd4));
    if (dest < 3'd4) begin
      check(req, "out_data", 32'(out_data[dest*DW +: DW]), 32'(d));
      check(req, "out_sop/eop", 32'({out_sop[dest], out_eop[dest]}), 32'({s, e}));
    end else begin
      check(req, "drop_data", 32'(drop_data), 32'(d));
      check(req, "drop_sop/eop", 32'({drop_sop, drop_eop}), 32'({s, e}));
      check(req, "drop_code", 32'(drop_code), 32'(code));
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    // R8: reset state
    check("R8", "out_valid in reset", 32'(out_valid), 32'h0);
    check("R8", "drop_valid in reset", 32'(drop_valid), 32'h0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R8", "in_ready after reset", 32'(in_ready), 32'h1);
    check("R8", "out_valid after reset", 32'(out_valid), 32'h0);

    // Table walk: two-beat packets with all consumers ready
    for (int v = 0; v < NV; v++) begin
      string rh;
      rh = (VECS[v].dest == 3'd4) ? ((VECS[v].code == 2'd2) ? "R6" : "R5") : "R1,R2,R3";
      send(VECS[v].hdr, 1'b1, 1'b0);
      expect_beat(rh, VECS[v].dest, VECS[v].ehdr, 1'b1, 1'b0, VECS[v].code);
      send(VECS[v].body, 1'b0, 1'b1);
      expect_beat("R4", VECS[v].dest, VECS[v].body, 1'b0, 1'b1, VECS[v].code);
    end

    // R10: body beats that look like headers follow the packet unchanged
    send(16'h68C0, 1'b1, 1'b0);
    expect_beat("R10", 3'd3, 16'h3600, 1'b1, 1'b0, 2'd0);
    send(16'h3200, 1'b1, 1'b0);  // would decode to egress 0, sop set mid-packet
    expect_beat("R10", 3'd3, 16'h3200, 1'b1, 1'b0, 2'd0);
    send(16'h0000, 1'b0, 1'b1);  // would decode as bad length
    expect_beat("R10", 3'd3, 16'h0000, 1'b0, 1'b1, 2'd0);

    // R4 and R10: single-beat packet, then the next first beat is decoded again
    send(16'h5780, 1'b1, 1'b1);
    expect_beat("R4", 3'd2, 16'h2C00, 1'b1, 1'b1, 2'd0);
    send(16'h3A00, 1'b1, 1'b1);
    expect_beat("R10", 3'd4, 16'h3A00, 1'b1, 1'b1, 2'd1);

    // R7/R9: egress 1 stalls; the second beat waits
    out_ready[1] = 1'b0;
    send(16'hC555, 1'b1, 1'b0);
    expect_beat("R7", 3'd1, 16'h9AA8, 1'b1, 1'b0, 2'd0);
    @(negedge clk);
    in_valid = 1'b1; in_data = 16'hBEEF; in_sop = 1'b0; in_eop = 1'b1;
    #1;
    check("R7", "in_ready while egress full", 32'(in_ready), 32'h0);
    @(posedge clk);
    #2;
    check("R9", "held valid", 32'(out_valid[1]), 32'h1);
    check("R9", "held data", 32'(out_data[1*DW +: DW]), 32'h9AA8);
    @(negedge clk);
    out_ready[1] = 1'b1;
    #1;
    check("R7", "in_ready after release", 32'(in_ready), 32'h1);
    @(posedge clk);
    #2;
    in_valid = 1'b0;
    expect_beat("R7", 3'd1, 16'hBEEF, 1'b0, 1'b1, 2'd0);

    // R9 on the discard stream: drop consumer stalls
    drop_ready = 1'b0;
    send(16'h4E00, 1'b1, 1'b1);
    expect_beat("R5", 3'd4, 16'h4E00, 1'b1, 1'b1, 2'd1);
    @(posedge clk);
    #2;
    check("R9", "drop held valid", 32'(drop_valid), 32'h1);
    check("R9", "drop held data", 32'(drop_data), 32'h4E00);
    drop_ready = 1'b1;
    @(posedge clk);
    #2;
    check("R9", "drop drained", 32'(drop_valid), 32'h0);

    done = 1'b1;
    finish_run();
  end

endmodule